// File: doc/BRIEF.md
# Multi-User Interprocessor Mailbox Controller

This block is a memory-mapped mailbox that processors use to pass 32-bit messages to each other. It holds a parameterised number of message queues and a parameterised number of users. A user is an interrupt destination, and each user has one level interrupt output. Software pushes a word by writing a queue's message register and pops the oldest word by reading it. Two other per-queue registers report whether the queue is full and how many words are still unread.

Every queue produces two events: one when a word arrives, and one when a pop frees space in a queue that was full. Both events are latched at once into the status register of every user. Status bits are cleared by writing ones to them. Each user owns an enable mask, and its interrupt line is high whenever an enabled status bit is set. A parameter selects between two register layouts. The current layout gives each user separate enable-set and enable-clear registers. The legacy layout gives each user a single read/write enable register. The register port is single-cycle: read data is valid in the same cycle as the access, and any pop or push takes effect at the clock edge that ends the access.

Top module: `mbx_ctrl`

## Requirements
- R1: Writing the message register of queue m (offset 0x040 + 4*m) appends the 32-bit word to that queue. Reading that register returns the oldest unread word and removes it, so words come out in the order they were written.
- R2: A write to a full queue is dropped and raises no event. A read from an empty queue returns 0 and changes no state.
- R3: The full-flag register of queue m (offset 0x080 + 4*m) reads 1 when the queue holds FIFO_DEPTH words and reads 0 otherwise.
- R4: The count register of queue m (offset 0x0C0 + 4*m) reads the number of unread words, and reads 0 when the queue is empty.
- R5: An accepted push into queue m sets bit 2*m in the status register of every user.
- R6: A pop that takes queue m from full to not full sets bit 2*m+1 in the status register of every user.
- R7: Writing a 1 to a status bit clears that bit for that user only. Bits written as 0 are kept. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R8: The interrupt output of user u is high exactly when some bit of (status AND enable) of user u is set. The output changes in the cycle after the register change that causes it.
- R9: Current layout (LEGACY_MAP=0): user u has its status register at 0x104 + 0x10*u, its enable-set register at 0x108 + 0x10*u and its enable-clear register at 0x10C + 0x10*u. A write to set or clear affects only the bits written as 1. Reading either register returns the enable mask.
- R10: Legacy layout (LEGACY_MAP=1): user u has its status register at 0x100 + 8*u and one read/write enable register at 0x104 + 8*u. A write there replaces the whole enable mask.
- R11: Offset 0x000 reads the REVISION parameter. Writes to that offset have no effect.
- R12: After reset, every queue is empty, every status and enable bit is clear, and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | NUM_USERS | Level interrupt, one per user |

## Verification
A queue pointer or count that has gone wrong shows up on the next message read as a wrong word or as a spurious zero. It also shows on the full-flag and count registers in the same cycle they are read. A status or enable bit that has been lost or set by mistake shows on the interrupt pins one cycle after the access that caused it. For that reason the interrupt lines are compared against the reference model on every clock. Both register layouts are exercised with the same sequence, so an address decode error in either one appears as a wrong read value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_REV      = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MSG      = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_FULL     = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_CNT      = 12'h0C0;
    localparam logic [ADDR_W-1:0] OFS_USR_CUR  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_USR_LEG  = 12'h100;
    localparam int                STRIDE_CUR   = 16;
    localparam int                STRIDE_LEG   = 8;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_REV,
        ACC_MSG,
        ACC_FULL,
        ACC_CNT,
        ACC_STAT,
        ACC_ENSET,
        ACC_ENCLR,
        ACC_ENRW
    } acc_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          new_evt_o,
    output logic          room_evt_o
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     empty, do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o     = (s_q.cnt == CW'(DEPTH));
    assign empty      = (s_q.cnt == '0);
    assign do_push    = push_i && !full_o;
    assign do_pop     = pop_i && !empty;
    assign new_evt_o  = do_push;
    assign room_evt_o = do_pop && full_o;
    assign head_o     = s_q.mem[s_q.rp];
    assign count_o    = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.mem[s_q.wp] = data_i;
            s_d.wp          = bump(s_q.wp);
        end
        if (do_pop) begin
            s_d.rp = bump(s_q.rp);
        end
        s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> $stable(count_o));

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count_o == '0) |=> (count_o == '0));
endmodule

// File: rtl/mbx_user.sv
module mbx_user #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] st_clr_i,
    input  logic [W-1:0] en_set_i,
    input  logic [W-1:0] en_clr_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] enable_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] st;
        logic [W-1:0] en;
    } usr_st_t;

    usr_st_t u_d, u_q;

    always_comb begin
        u_d    = u_q;
        u_d.st = (u_q.st & ~st_clr_i) | evt_i;
        u_d.en = (u_q.en & ~en_clr_i) | en_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    assign status_o = u_q.st;
    assign enable_o = u_q.en;
    assign irq_o    = |(u_q.st & u_q.en);

    // R5
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |=> ((status_o & $past(st_clr_i)) == '0));

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_i == '0 && en_clr_i == '0) |=> $stable(enable_o));
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int          NUM_FIFOS  = 4,
    parameter int          NUM_USERS  = 3,
    parameter int          FIFO_DEPTH = 4,
    parameter bit          LEGACY_MAP = 1'b0,
    parameter logic [31:0] REVISION   = 32'h0003_0105,
    localparam int         W          = 2 * NUM_FIFOS,
    localparam int         FW         = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1,
    localparam int         UW         = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
    localparam int         CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_USERS-1:0] irq_o
);
    acc_e          kind;
    logic [FW-1:0] fsel;
    logic [UW-1:0] usel;

    logic [31:0]   head   [NUM_FIFOS];
    logic [CW-1:0] cnt    [NUM_FIFOS];
    logic          full   [NUM_FIFOS];
    logic [W-1:0]  evt;
    logic [W-1:0]  status [NUM_USERS];
    logic [W-1:0]  enable [NUM_USERS];
    logic          unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    always_comb begin
        kind = ACC_NONE;
        fsel = '0;
        usel = '0;
        if (bus_sel) begin
            if (bus_addr == OFS_REV) kind = ACC_REV;
            for (int m = 0; m < NUM_FIFOS; m++) begin
                if (bus_addr == OFS_MSG + 12'(4 * m)) begin
                    kind = ACC_MSG;  fsel = FW'(m);
                end
                if (bus_addr == OFS_FULL + 12'(4 * m)) begin
                    kind = ACC_FULL; fsel = FW'(m);
                end
                if (bus_addr == OFS_CNT + 12'(4 * m)) begin
                    kind = ACC_CNT;  fsel = FW'(m);
                end
            end
            for (int u = 0; u < NUM_USERS; u++) begin
                if (LEGACY_MAP) begin
                    if (bus_addr == OFS_USR_LEG + 12'(STRIDE_LEG * u)) begin
                        kind = ACC_STAT; usel = UW'(u);
                    end
                    if (bus_addr == OFS_USR_LEG + 12'(STRIDE_LEG * u + 4)) begin
                        kind = ACC_ENRW; usel = UW'(u);
                    end
                end else begin
                    if (bus_addr == OFS_USR_CUR + 12'(STRIDE_CUR * u)) begin
                        kind = ACC_STAT;  usel = UW'(u);
                    end
                    if (bus_addr == OFS_USR_CUR + 12'(STRIDE_CUR * u + 4)) begin
                        kind = ACC_ENSET; usel = UW'(u);
                    end
                    if (bus_addr == OFS_USR_CUR + 12'(STRIDE_CUR * u + 8)) begin
                        kind = ACC_ENCLR; usel = UW'(u);
                    end
                end
            end
        end
    end

    generate
        for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
            logic push, pop;
            assign push = (kind == ACC_MSG) && bus_wr  && (fsel == FW'(m));
            assign pop  = (kind == ACC_MSG) && !bus_wr && (fsel == FW'(m));
            mbx_fifo #(.DEPTH(FIFO_DEPTH), .DW(32)) u_fifo (
                .clk        (clk),
                .rst_n      (rst_n),
                .push_i     (push),
                .pop_i      (pop),
                .data_i     (bus_wdata),
                .head_o     (head[m]),
                .count_o    (cnt[m]),
                .full_o     (full[m]),
                .new_evt_o  (evt[2*m]),
                .room_evt_o (evt[2*m+1])
            );
        end

        for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
            logic         hit, wr_hit;
            logic [W-1:0] st_clr, en_set, en_clr;
            assign hit    = (usel == UW'(u));
            assign wr_hit = hit && bus_wr;
            assign st_clr = (wr_hit && kind == ACC_STAT) ? bus_wdata[W-1:0] : '0;
            assign en_set = (wr_hit && (kind == ACC_ENSET || kind == ACC_ENRW))
                            ? bus_wdata[W-1:0] : '0;
            assign en_clr = (wr_hit && kind == ACC_ENCLR) ? bus_wdata[W-1:0]
                          : (wr_hit && kind == ACC_ENRW)  ? ~bus_wdata[W-1:0] : '0;
            mbx_user #(.W(W)) u_user (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt_i    (evt),
                .st_clr_i (st_clr),
                .en_set_i (en_set),
                .en_clr_i (en_clr),
                .status_o (status[u]),
                .enable_o (enable[u]),
                .irq_o    (irq_o[u])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            unique case (kind)
                ACC_REV:  bus_rdata = REVISION;
                ACC_MSG:  bus_rdata = (cnt[fsel] != '0) ? head[fsel] : '0;
                ACC_FULL: bus_rdata = {31'd0, full[fsel]};
                ACC_CNT:  bus_rdata = 32'(cnt[fsel]);
                ACC_STAT: bus_rdata = 32'(status[usel]);
                ACC_ENSET, ACC_ENCLR, ACC_ENRW:
                          bus_rdata = 32'(enable[usel]);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R11
    rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_REV) |-> (bus_rdata == REVISION));

    // R2
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_MSG && !bus_wr && cnt[fsel] == '0) |-> (bus_rdata == '0));

    // R12
    irq_reset_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_o == '0));
endmodule

// File: tb/tb_mbx_ctrl.sv
module tb_mbx_ctrl;
    localparam int          CLK_NS = 10;
    localparam int          NF     = 4;
    localparam int          NU     = 3;
    localparam int          DEPTH  = 4;
    localparam int          W      = 2 * NF;
    localparam logic [31:0] REV    = 32'h0003_0105;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel   [2];
    logic        wr    [2];
    logic [11:0] addr  [2];
    logic [31:0] wdata [2];
    logic [31:0] rdata [2];
    logic [NU-1:0] irq [2];

    int unsigned  mq  [2][NF][$];
    logic [W-1:0] mst [2][NU];
    logic [W-1:0] men [2][NU];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    mbx_ctrl #(.NUM_FIFOS(NF), .NUM_USERS(NU), .FIFO_DEPTH(DEPTH),
               .LEGACY_MAP(1'b0), .REVISION(REV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel[0]), .bus_wr(wr[0]),
        .bus_addr(addr[0]), .bus_wdata(wdata[0]), .bus_rdata(rdata[0]),
        .irq_o(irq[0]));

    mbx_ctrl #(.NUM_FIFOS(NF), .NUM_USERS(NU), .FIFO_DEPTH(DEPTH),
               .LEGACY_MAP(1'b1), .REVISION(REV)) dut_leg (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel[1]), .bus_wr(wr[1]),
        .bus_addr(addr[1]), .bus_wdata(wdata[1]), .bus_rdata(rdata[1]),
        .irq_o(irq[1]));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] st_a(input int d, input int u);
        return (d == 1) ? 12'(12'h100 + 8 * u) : 12'(12'h104 + 16 * u);
    endfunction
    function automatic logic [11:0] ens_a(input int d, input int u);
        return (d == 1) ? 12'(12'h104 + 8 * u) : 12'(12'h108 + 16 * u);
    endfunction
    function automatic logic [11:0] enc_a(input int u);
        return 12'(12'h10C + 16 * u);
    endfunction

    function automatic logic [31:0] model_read(input int d, input logic [11:0] a);
        if (a == 12'h000) return REV;
        for (int m = 0; m < NF; m++) begin
            if (a == 12'(12'h040 + 4 * m))
                return (mq[d][m].size() > 0) ? mq[d][m][0] : 32'd0;
            if (a == 12'(12'h080 + 4 * m))
                return (mq[d][m].size() == DEPTH) ? 32'd1 : 32'd0;
            if (a == 12'(12'h0C0 + 4 * m))
                return 32'(mq[d][m].size());
        end
        for (int u = 0; u < NU; u++) begin
            if (a == st_a(d, u)) return 32'(mst[d][u]);
            if (a == ens_a(d, u)) return 32'(men[d][u]);
            if (d == 0 && a == enc_a(u)) return 32'(men[d][u]);
        end
        return 32'd0;
    endfunction

    task automatic model_update(input int d, input bit w, input logic [11:0] a,
                                input logic [31:0] v);
        for (int m = 0; m < NF; m++) begin
            if (a == 12'(12'h040 + 4 * m)) begin
                if (w && mq[d][m].size() < DEPTH) begin
                    mq[d][m].push_back(v);
                    for (int u = 0; u < NU; u++) mst[d][u][2*m] = 1'b1;
                end else if (!w && mq[d][m].size() > 0) begin
                    if (mq[d][m].size() == DEPTH)
                        for (int u = 0; u < NU; u++) mst[d][u][2*m+1] = 1'b1;
                    void'(mq[d][m].pop_front());
                end
            end
        end
        if (w) begin
            for (int u = 0; u < NU; u++) begin
                if (a == st_a(d, u)) mst[d][u] = mst[d][u] & ~v[W-1:0];
                if (d == 0 && a == ens_a(d, u)) men[d][u] = men[d][u] | v[W-1:0];
                if (d == 0 && a == enc_a(u))    men[d][u] = men[d][u] & ~v[W-1:0];
                if (d == 1 && a == ens_a(d, u)) men[d][u] = v[W-1:0];
            end
        end
    endtask

    task automatic acc(input int d, input bit w, input logic [11:0] a,
                       input logic [31:0] v, input string tag);
        @(negedge clk);
        sel[d] = 1'b1; wr[d] = w; addr[d] = a; wdata[d] = v;
        #1;
        if (!w) check(tag, rdata[d], model_read(d, a));
        @(posedge clk);
        model_update(d, w, a, v);
        #1;
        sel[d] = 1'b0; wr[d] = 1'b0;
    endtask

    // R8: interrupt lines compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int d = 0; d < 2; d++)
                for (int u = 0; u < NU; u++)
                    check("R8 irq", 32'(irq[d][u]), 32'(|(mst[d][u] & men[d][u])));
        end
    end

    task automatic run_seq(input int d);
        for (int m = 0; m < NF; m++) begin
            acc(d, 0, 12'(12'h0C0 + 4 * m), 0, "R12 count");
            acc(d, 0, 12'(12'h080 + 4 * m), 0, "R12 full");
        end
        for (int u = 0; u < NU; u++) begin
            acc(d, 0, st_a(d, u), 0, "R12 status");
            acc(d, 0, ens_a(d, u), 0, "R12 enable");
        end
        acc(d, 0, 12'h000, 0, "R11 revision");
        acc(d, 1, 12'h000, 32'hDEAD_BEEF, "R11");
        acc(d, 0, 12'h000, 0, "R11 revision after write");

        acc(d, 1, ens_a(d, 0), 32'h01, (d == 0) ? "R9" : "R10");
        acc(d, 1, ens_a(d, 2), (d == 0) ? 32'h08 : 32'h08, (d == 0) ? "R9" : "R10");
        acc(d, 1, 12'h040, 32'h0000_00A1, "R1");
        acc(d, 0, st_a(d, 1), 0, "R5 status other user");
        acc(d, 0, st_a(d, 2), 0, "R5 status");
        acc(d, 1, st_a(d, 0), 32'h01, "R7");
        acc(d, 0, st_a(d, 0), 0, "R7 cleared");
        acc(d, 0, st_a(d, 1), 0, "R7 other user kept");

        for (int i = 0; i < 5; i++) acc(d, 1, 12'h044, 32'h0000_00B0 + i, "R2");
        acc(d, 0, 12'h084, 0, "R3 full");
        acc(d, 0, 12'h0C4, 0, "R4 count full");
        acc(d, 0, 12'h044, 0, "R1 oldest first");
        acc(d, 0, st_a(d, 0), 0, "R6 not-full event");
        acc(d, 0, 12'h084, 0, "R3 not full");
        acc(d, 0, 12'h0C4, 0, "R4 count");
        for (int i = 0; i < 3; i++) acc(d, 0, 12'h044, 0, "R1 order");
        acc(d, 0, 12'h044, 0, "R2 empty read");
        acc(d, 0, 12'h0C4, 0, "R4 empty");
        acc(d, 0, 12'h040, 0, "R1 queue 0");
        acc(d, 0, st_a(d, 2), 0, "R6 status");

        if (d == 0) begin
            acc(d, 1, ens_a(d, 1), 32'hFF, "R9");
            acc(d, 1, enc_a(1), 32'h0F, "R9");
            acc(d, 0, ens_a(d, 1), 0, "R9 set readback");
            acc(d, 0, enc_a(1), 0, "R9 clear readback");
        end else begin
            acc(d, 1, ens_a(d, 1), 32'h5A, "R10");
            acc(d, 0, ens_a(d, 1), 0, "R10 readback");
            acc(d, 1, ens_a(d, 1), 32'h05, "R10");
            acc(d, 0, ens_a(d, 1), 0, "R10 replace");
        end
        for (int u = 0; u < NU; u++) acc(d, 1, st_a(d, u), 32'hFF, "R7");
        for (int u = 0; u < NU; u++) acc(d, 0, st_a(d, u), 0, "R7 all clear");
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            sel[d] = 1'b0; wr[d] = 1'b0; addr[d] = '0; wdata[d] = '0;
            for (int u = 0; u < NU; u++) begin
                mst[d][u] = '0; men[d][u] = '0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int d = 0; d < 2; d++) check("R12 irq", 32'(irq[d]), 32'd0);
        for (int d = 0; d < 2; d++) run_seq(d);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule